// File: doc/BRIEF.md
# PCI Base Address Register File

This block holds the base address registers of a PCI configuration header and the fixed identity bytes around them. Software reaches it through a dword-wide configuration port that has per-byte write enables and a read path with a one-cycle delay. Each of the six BAR slots is set by parameter to one of three kinds: unused, 32-bit memory, or the low half of a 64-bit memory region. A 64-bit region also takes the slot that follows it. The log2 of each region size fixes which address bits software may write. Software sizes a region by writing all ones and reading the value back. The expansion ROM register has the same sizing behaviour and also has a writable enable bit.

The block drives the programmed base of every slot on an output. It also compares a 64-bit memory address against each mapped region and raises one hit bit per slot, plus one bit for the ROM. A parameter selects a bridge header. With that header only the first two slots are implemented, and the ROM register moves to dword 14.

Top module: `pci_bar_regs`

## Requirements
- R1: After reset, a 32-bit memory slot reads 0x00000000 and a 64-bit low slot reads 0x00000004. The type field is bits 3:0: 0000 means 32-bit memory and 0100 means 64-bit memory.
- R2: After 0xFFFFFFFF is written to a 32-bit memory slot of size 2^s, it reads ~(2^s-1) with the type bits ORed in. For example, a 1 MiB slot reads 0xFFF00000.
- R3: A 64-bit region spans dwords 4+i and 5+i and uses one 64-bit mask. After all ones is written, the low dword reads the low half of ~(2^s-1) ORed with 0x4, and the upper dword reads the high half of the mask.
- R4: The ROM register sits at dword 12 (dword 14 for a bridge header). After all ones is written it reads ~(2^s-1) with bit 0 set, and bit 0 (the enable) is writable.
- R5: Each of the four byte enables updates its own byte lane. Within each enabled lane, only the bits allowed by the write mask change.
- R6: The type bits are read-only. Writing zero to a 64-bit low slot leaves 0x00000004.
- R7: A slot of kind unused reads zero and ignores writes.
- R8: With the bridge header, slots 2 to 5 and dword 12 read zero and ignore writes, and dword 3 bits 23:16 read 0x01.
- R9: The identity dwords are read-only. Dword 0 = {device, vendor}, dword 2 = {class, revision}, dword 3 bits 23:16 = header type, dword 15 bits 15:8 = interrupt pin.
- R10: A read request presents its data and a valid pulse in the cycle after the request, and valid is low otherwise.
- R11: A 32-bit slot hits only if address bits 63:32 are zero, the bits above the size boundary equal the base, and the base is not zero (the unmapped value).
- R12: A 64-bit region hits on a full 64-bit compare of the bits above its size boundary, reported on the bit of its low slot.
- R13: The ROM hits only while its enable bit is set and its base is nonzero. Its hit is reported on bit 6.
- R14: barBase slice i carries slot i with its type bits cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Configuration write request |
| cfgRdEn | input | 1 | Configuration read request |
| cfgAddr | input | 6 | Dword index into the header |
| cfgByteEn | input | 4 | Byte-lane write enables |
| cfgWrData | input | 32 | Write data |
| cfgRdData | output | 32 | Read data, registered |
| cfgRdValid | output | 1 | Read data valid |
| memAddr | input | 64 | Memory address to decode |
| memHit | output | 7 | Per-slot hit bits; bit 6 is the ROM |
| barBase | output | 192 | Programmed base of each slot, 32 bits per slot |

## Verification
Four behaviours are checked by assertions on every cycle: the one-cycle read valid timing, the rule that a byte lane with its enable clear is left unchanged, the rejection of slots above index 1 under a bridge header, and the rule that a ROM or 32-bit hit never occurs without its enable or with upper address bits set. The bench scenarios are the only way to show the sizing readbacks, the mask values, the 64-bit upper dword, the identity bytes and the exact address boundaries where a hit starts or stops. Each of these depends on parameter-derived values that the bench computes on its own.

// File: rtl/pci_bar_pkg.sv
package pci_bar_pkg;

  localparam int NSLOT = 6;
  localparam int KW = 2;
  localparam int LW = 6;

  localparam logic [1:0] KIND_NONE = 2'd0;
  localparam logic [1:0] KIND_M32  = 2'd1;
  localparam logic [1:0] KIND_M64  = 2'd2;

  typedef struct packed {
    logic [NSLOT-1:0] wrSlot;
    logic             wrRom;
    logic [3:0]       byteEn;
    logic             rdReq;
    logic [5:0]       rdAddr;
  } cfg_stb_t;

  function automatic logic [1:0] kindAt(input logic [KW*NSLOT-1:0] kinds, input int i);
    return kinds[KW*i +: KW];
  endfunction

  function automatic int log2At(input logic [LW*NSLOT-1:0] sizes, input int i);
    return int'(sizes[LW*i +: LW]);
  endfunction

  function automatic logic isUpper(input logic [KW*NSLOT-1:0] kinds, input int i);
    if (i == 0) return 1'b0;
    return kindAt(kinds, i-1) == KIND_M64;
  endfunction

  function automatic logic slotLive(input logic [KW*NSLOT-1:0] kinds, input logic bridge, input int i);
    if (bridge && i >= 2) return 1'b0;
    if (kindAt(kinds, i) != KIND_NONE) return 1'b1;
    return isUpper(kinds, i);
  endfunction

  function automatic logic [63:0] wideMask(input int s);
    return ~((64'd1 << s) - 64'd1);
  endfunction

  function automatic logic [31:0] slotMask(input logic [KW*NSLOT-1:0] kinds,
                                           input logic [LW*NSLOT-1:0] sizes,
                                           input logic bridge, input int i);
    logic [63:0] m;
    if (!slotLive(kinds, bridge, i)) return 32'd0;
    if (kindAt(kinds, i) == KIND_NONE) begin
      m = wideMask(log2At(sizes, i-1));
      return m[63:32];
    end
    m = wideMask(log2At(sizes, i));
    return m[31:0];
  endfunction

  function automatic logic [31:0] slotType(input logic [KW*NSLOT-1:0] kinds, input logic bridge, input int i);
    if (slotLive(kinds, bridge, i) && kindAt(kinds, i) == KIND_M64) return 32'h4;
    return 32'h0;
  endfunction

  function automatic logic [31:0] romMask(input int s);
    logic [63:0] m;
    if (s == 0) return 32'd0;
    m = wideMask(s);
    return m[31:0] | 32'h1;
  endfunction

endpackage

// File: rtl/pci_bar_ctrl.sv
module pci_bar_ctrl
  import pci_bar_pkg::*;
#(
  parameter logic [KW*NSLOT-1:0] BAR_KIND = '0,
  parameter logic                IS_BRIDGE = 1'b0,
  parameter int                  ROM_LOG2 = 0
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cfgWrEn,
  input  logic       cfgRdEn,
  input  logic [5:0] cfgAddr,
  input  logic [3:0] cfgByteEn,
  output cfg_stb_t   stb,
  output logic       cfgRdValid
);

  localparam logic [5:0] BAR_BASE_DW = 6'd4;
  localparam logic [5:0] ROM_DW = IS_BRIDGE ? 6'd14 : 6'd12;
  localparam logic HAS_ROM = (ROM_LOG2 != 0);

  logic [NSLOT-1:0] slotWr;

  for (genvar i = 0; i < NSLOT; i++) begin : g_dec
    localparam logic LIVE = slotLive(BAR_KIND, IS_BRIDGE, i);
    localparam logic [5:0] DW = BAR_BASE_DW + 6'(i);
    if (LIVE) begin : g_live
      assign slotWr[i] = cfgWrEn && (cfgAddr == DW);
    end else begin : g_dead
      assign slotWr[i] = 1'b0;
      if (IS_BRIDGE && i >= 2) begin : g_rej
        // R8
        bridge_reject_chk: assert property (@(posedge clk) disable iff (!rstN)
          (cfgWrEn && cfgAddr == DW) |-> !stb.wrSlot[i]);
      end
    end
  end

  always_comb begin
    stb.wrSlot = slotWr;
    stb.wrRom  = HAS_ROM && cfgWrEn && (cfgAddr == ROM_DW);
    stb.byteEn = cfgByteEn;
    stb.rdReq  = cfgRdEn;
    stb.rdAddr = cfgAddr;
  end

  always_ff @(posedge clk) begin
    if (!rstN) cfgRdValid <= 1'b0;
    else       cfgRdValid <= cfgRdEn;
  end

  // R10
  rd_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    cfgRdEn |=> cfgRdValid);
  // R10
  rd_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cfgRdEn |=> !cfgRdValid);

endmodule

// File: rtl/pci_bar_dp.sv
module pci_bar_dp
  import pci_bar_pkg::*;
#(
  parameter logic [KW*NSLOT-1:0] BAR_KIND  = '0,
  parameter logic [LW*NSLOT-1:0] BAR_LOG2  = '0,
  parameter logic                IS_BRIDGE = 1'b0,
  parameter int                  ROM_LOG2  = 0,
  parameter logic [15:0]         VENDOR_ID = 16'h1af0,
  parameter logic [15:0]         DEVICE_ID = 16'h11e8,
  parameter logic [7:0]          REV_ID    = 8'h10,
  parameter logic [23:0]         CLASS_ID  = 24'hff0000,
  parameter logic [7:0]          IRQ_PIN   = 8'h01
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  cfg_stb_t              stb,
  input  logic [31:0]           wrData,
  input  logic [63:0]           memAddr,
  output logic [31:0]           rdData,
  output logic [NSLOT:0]        memHit,
  output logic [NSLOT*32-1:0]   barBase
);

  localparam logic [5:0] ROM_DW = IS_BRIDGE ? 6'd14 : 6'd12;
  localparam logic [31:0] ROM_MASK = romMask(ROM_LOG2);
  localparam logic [31:0] ROM_ADDR_MASK = ROM_MASK & ~32'h1;
  localparam logic [7:0] HDR_BYTE = IS_BRIDGE ? 8'h01 : 8'h00;

  logic [31:0] laneBits;
  logic [31:0] slotVal [NSLOT];
  logic [31:0] romVal;
  logic [31:0] rdMux;

  always_comb begin
    for (int k = 0; k < 4; k++) laneBits[k*8 +: 8] = {8{stb.byteEn[k]}};
  end

  for (genvar i = 0; i < NSLOT; i++) begin : g_slot
    localparam logic LIVE = slotLive(BAR_KIND, IS_BRIDGE, i);
    localparam logic [31:0] MASK = slotMask(BAR_KIND, BAR_LOG2, IS_BRIDGE, i);
    localparam logic [31:0] TYPEB = slotType(BAR_KIND, IS_BRIDGE, i);
    localparam logic [1:0] KIND = kindAt(BAR_KIND, i);

    if (LIVE) begin : g_reg
      logic [31:0] q;
      logic [31:0] upd;
      assign upd = MASK & laneBits;
      always_ff @(posedge clk) begin
        if (!rstN)                q <= TYPEB;
        else if (stb.wrSlot[i])   q <= (q & ~upd) | (wrData & upd);
      end
      assign slotVal[i] = q;

      for (genvar k = 0; k < 4; k++) begin : g_lane
        // R5
        lane_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
          (stb.wrSlot[i] && !stb.byteEn[k]) |=> $stable(q[k*8 +: 8]));
      end
    end else begin : g_none
      assign slotVal[i] = 32'd0;
    end

    assign barBase[i*32 +: 32] = slotVal[i] & MASK;

    if (LIVE && KIND == KIND_M32) begin : g_hit32
      logic [31:0] base;
      assign base = slotVal[i] & MASK;
      assign memHit[i] = (memAddr[63:32] == 32'd0) &&
                         ((memAddr[31:0] & MASK) == base) && (base != 32'd0);
      // R11
      hit32_upper_chk: assert property (@(posedge clk) disable iff (!rstN)
        memHit[i] |-> (memAddr[63:32] == 32'd0));
    end else if (LIVE && KIND == KIND_M64 && i < NSLOT-1) begin : g_hit64
      localparam logic [31:0] MASK_HI = slotMask(BAR_KIND, BAR_LOG2, IS_BRIDGE, i+1);
      localparam logic [63:0] MASK64 = {MASK_HI, MASK};
      logic [63:0] base64;
      assign base64 = {slotVal[i+1], slotVal[i]} & MASK64;
      assign memHit[i] = ((memAddr & MASK64) == base64) && (base64 != 64'd0);
    end else begin : g_nohit
      assign memHit[i] = 1'b0;
    end
  end

  if (ROM_LOG2 != 0) begin : g_rom
    logic [31:0] q;
    logic [31:0] upd;
    logic [31:0] base;
    assign upd = ROM_MASK & laneBits;
    always_ff @(posedge clk) begin
      if (!rstN)          q <= 32'd0;
      else if (stb.wrRom) q <= (q & ~upd) | (wrData & upd);
    end
    assign romVal = q;
    assign base = q & ROM_ADDR_MASK;
    assign memHit[NSLOT] = q[0] && (memAddr[63:32] == 32'd0) &&
                           ((memAddr[31:0] & ROM_ADDR_MASK) == base) && (base != 32'd0);
    // R13
    rom_enable_chk: assert property (@(posedge clk) disable iff (!rstN)
      memHit[NSLOT] |-> romVal[0]);
  end else begin : g_norom
    assign romVal = 32'd0;
    assign memHit[NSLOT] = 1'b0;
  end

  always_comb begin
    rdMux = 32'd0;
    case (stb.rdAddr)
      6'd0:  rdMux = {DEVICE_ID, VENDOR_ID};
      6'd2:  rdMux = {CLASS_ID, REV_ID};
      6'd3:  rdMux = {8'h00, HDR_BYTE, 16'h0000};
      6'd4:  rdMux = slotVal[0];
      6'd5:  rdMux = slotVal[1];
      6'd6:  rdMux = slotVal[2];
      6'd7:  rdMux = slotVal[3];
      6'd8:  rdMux = slotVal[4];
      6'd9:  rdMux = slotVal[5];
      6'd15: rdMux = {16'h0000, IRQ_PIN, 8'h00};
      default: rdMux = 32'd0;
    endcase
    if (stb.rdAddr == ROM_DW) rdMux = romVal;
  end

  always_ff @(posedge clk) begin
    if (!rstN)          rdData <= 32'd0;
    else if (stb.rdReq) rdData <= rdMux;
  end

endmodule

// File: rtl/pci_bar_regs.sv
module pci_bar_regs
  import pci_bar_pkg::*;
#(
  parameter logic [KW*NSLOT-1:0] BAR_KIND  = {2'd0, 2'd0, 2'd1, 2'd0, 2'd2, 2'd1},
  parameter logic [LW*NSLOT-1:0] BAR_LOG2  = {6'd0, 6'd0, 6'd12, 6'd0, 6'd14, 6'd20},
  parameter logic                IS_BRIDGE = 1'b0,
  parameter int                  ROM_LOG2  = 16,
  parameter logic [15:0]         VENDOR_ID = 16'h1af0,
  parameter logic [15:0]         DEVICE_ID = 16'h11e8,
  parameter logic [7:0]          REV_ID    = 8'h10,
  parameter logic [23:0]         CLASS_ID  = 24'hff0000,
  parameter logic [7:0]          IRQ_PIN   = 8'h01
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cfgWrEn,
  input  logic                cfgRdEn,
  input  logic [5:0]          cfgAddr,
  input  logic [3:0]          cfgByteEn,
  input  logic [31:0]         cfgWrData,
  output logic [31:0]         cfgRdData,
  output logic                cfgRdValid,
  input  logic [63:0]         memAddr,
  output logic [NSLOT:0]      memHit,
  output logic [NSLOT*32-1:0] barBase
);

  cfg_stb_t stb;

  pci_bar_ctrl #(
    .BAR_KIND(BAR_KIND), .IS_BRIDGE(IS_BRIDGE), .ROM_LOG2(ROM_LOG2)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgRdEn(cfgRdEn),
    .cfgAddr(cfgAddr), .cfgByteEn(cfgByteEn), .stb(stb), .cfgRdValid(cfgRdValid)
  );

  pci_bar_dp #(
    .BAR_KIND(BAR_KIND), .BAR_LOG2(BAR_LOG2), .IS_BRIDGE(IS_BRIDGE),
    .ROM_LOG2(ROM_LOG2), .VENDOR_ID(VENDOR_ID), .DEVICE_ID(DEVICE_ID),
    .REV_ID(REV_ID), .CLASS_ID(CLASS_ID), .IRQ_PIN(IRQ_PIN)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .wrData(cfgWrData), .memAddr(memAddr),
    .rdData(cfgRdData), .memHit(memHit), .barBase(barBase)
  );

endmodule

// File: tb/pci_bar_regs_tb.sv
module pci_bar_regs_tb;

  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic        cfgRdEn = 1'b0;
  logic [5:0]  cfgAddr = '0;
  logic [3:0]  cfgByteEn = '0;
  logic [31:0] cfgWrData = '0;
  logic [63:0] memAddr = '0;
  logic [31:0] rdData, brgRdData;
  logic        rdValid, brgRdValid;
  logic [6:0]  memHit, brgHit;
  logic [191:0] barBase, brgBase;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pci_bar_regs u_dut (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgRdEn(cfgRdEn), .cfgAddr(cfgAddr),
    .cfgByteEn(cfgByteEn), .cfgWrData(cfgWrData), .cfgRdData(rdData),
    .cfgRdValid(rdValid), .memAddr(memAddr), .memHit(memHit), .barBase(barBase)
  );

  pci_bar_regs #(
    .BAR_KIND({2'd0, 2'd0, 2'd0, 2'd1, 2'd1, 2'd1}),
    .BAR_LOG2({6'd0, 6'd0, 6'd0, 6'd12, 6'd16, 6'd12}),
    .IS_BRIDGE(1'b1), .ROM_LOG2(16)
  ) u_brg (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgRdEn(cfgRdEn), .cfgAddr(cfgAddr),
    .cfgByteEn(cfgByteEn), .cfgWrData(cfgWrData), .cfgRdData(brgRdData),
    .cfgRdValid(brgRdValid), .memAddr(memAddr), .memHit(brgHit), .barBase(brgBase)
  );

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, got, exp);
    end
  endtask

  task automatic cfgWrite(input logic [5:0] a, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgAddr = a; cfgWrData = d; cfgByteEn = be;
    @(negedge clk);
    cfgWrEn = 1'b0; cfgByteEn = 4'h0;
  endtask

  task automatic cfgRead(input logic [5:0] a, output logic [31:0] dv, output logic [31:0] bv);
    @(negedge clk);
    cfgRdEn = 1'b1; cfgAddr = a;
    @(negedge clk);
    cfgRdEn = 1'b0;
    chk("R10 valid", {63'd0, rdValid}, 64'd1);
    dv = rdData; bv = brgRdData;
  endtask

  task automatic rdChk(input string req, input logic [5:0] a, input logic [31:0] exp);
    logic [31:0] dv, bv;
    cfgRead(a, dv, bv);
    chk(req, {32'd0, dv}, {32'd0, exp});
  endtask

  task automatic hitChk(input string req, input logic [63:0] a, input logic [6:0] exp);
    @(negedge clk);
    memAddr = a;
    #1;
    chk(req, {57'd0, memHit}, {57'd0, exp});
  endtask

  task automatic testReset();
    chk("R10 idle", {63'd0, rdValid}, 64'd0);
    rdChk("R1 m32", 6'd4, 32'h0000_0000);
    rdChk("R1 m64", 6'd5, 32'h0000_0004);
    @(negedge clk);
    chk("R10 drop", {63'd0, rdValid}, 64'd0);
  endtask

  task automatic testIdent();
    rdChk("R9 dw0", 6'd0, 32'h11e8_1af0);
    rdChk("R9 dw2", 6'd2, 32'hff00_0010);
    rdChk("R9 dw3", 6'd3, 32'h0000_0000);
    rdChk("R9 pin", 6'd15, 32'h0000_0100);
    cfgWrite(6'd0, 32'hffff_ffff, 4'hf);
    rdChk("R9 ro", 6'd0, 32'h11e8_1af0);
  endtask

  task automatic testSizing();
    cfgWrite(6'd4, 32'hffff_ffff, 4'hf);
    rdChk("R2 1MiB", 6'd4, 32'hfff0_0000);
    cfgWrite(6'd7, 32'hffff_ffff, 4'hf);
    rdChk("R2 4KiB", 6'd7, 32'hffff_f000);
    cfgWrite(6'd5, 32'hffff_ffff, 4'hf);
    rdChk("R3 lo", 6'd5, 32'hffff_c004);
    cfgWrite(6'd6, 32'hffff_ffff, 4'hf);
    rdChk("R3 hi", 6'd6, 32'hffff_ffff);
    cfgWrite(6'd5, 32'h0000_0000, 4'hf);
    rdChk("R6 type", 6'd5, 32'h0000_0004);
  endtask

  task automatic testUnused();
    cfgWrite(6'd8, 32'hffff_ffff, 4'hf);
    rdChk("R7 s4", 6'd8, 32'h0);
    cfgWrite(6'd9, 32'hffff_ffff, 4'hf);
    rdChk("R7 s5", 6'd9, 32'h0);
  endtask

  task automatic testRom();
    cfgWrite(6'd12, 32'hffff_ffff, 4'hf);
    rdChk("R4 size", 6'd12, 32'hffff_0001);
    cfgWrite(6'd12, 32'h0, 4'hf);
    rdChk("R4 clr", 6'd12, 32'h0);
  endtask

  task automatic testLanes();
    cfgWrite(6'd4, 32'h0, 4'hf);
    cfgWrite(6'd4, 32'habcd_ef12, 4'b1000);
    rdChk("R5 lane3", 6'd4, 32'hab00_0000);
    cfgWrite(6'd4, 32'h00cd_0000, 4'b0100);
    rdChk("R5 lane2", 6'd4, 32'habc0_0000);
  endtask

  task automatic testHit();
    cfgWrite(6'd4, 32'hc000_0000, 4'hf);
    @(negedge clk);
    chk("R14 base0", {32'd0, barBase[31:0]}, 64'hc000_0000);
    hitChk("R11 in", 64'h0000_0000_c00f_fffc, 7'b0000001);
    hitChk("R11 edge", 64'h0000_0000_c010_0000, 7'b0000000);
    hitChk("R11 upper", 64'h0000_0001_c00f_fffc, 7'b0000000);
    cfgWrite(6'd5, 32'h2345_0000, 4'hf);
    cfgWrite(6'd6, 32'h0000_0001, 4'hf);
    @(negedge clk);
    chk("R14 base1", {32'd0, barBase[63:32]}, 64'h2345_0000);
    hitChk("R12 in", 64'h0000_0001_2345_3ff0, 7'b0000010);
    hitChk("R12 hi0", 64'h0000_0000_2345_0000, 7'b0000000);
    cfgWrite(6'd7, 32'h0, 4'hf);
    hitChk("R11 unmapped", 64'h0000_0000_0000_0010, 7'b0000000);
    cfgWrite(6'd12, 32'hd000_0000, 4'hf);
    hitChk("R13 off", 64'h0000_0000_d000_0010, 7'b0000000);
    cfgWrite(6'd12, 32'hd000_0001, 4'hf);
    hitChk("R13 on", 64'h0000_0000_d000_0010, 7'b1000000);
  endtask

  task automatic testBridge();
    logic [31:0] dv, bv;
    cfgWrite(6'd6, 32'hffff_ffff, 4'hf);
    cfgRead(6'd6, dv, bv);
    chk("R8 slot2", {32'd0, bv}, 64'h0);
    cfgWrite(6'd5, 32'hffff_ffff, 4'hf);
    cfgRead(6'd5, dv, bv);
    chk("R8 slot1", {32'd0, bv}, 64'hffff_0000);
    cfgWrite(6'd14, 32'hffff_ffff, 4'hf);
    cfgRead(6'd14, dv, bv);
    chk("R8 rom14", {32'd0, bv}, 64'hffff_0001);
    cfgRead(6'd12, dv, bv);
    chk("R8 dw12", {32'd0, bv}, 64'h0);
    cfgRead(6'd3, dv, bv);
    chk("R8 hdr", {32'd0, bv}, 64'h0001_0000);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testIdent();
    testSizing();
    testUnused();
    testRom();
    testLanes();
    testHit();
    testBridge();
    repeat (2) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule